// File: doc/BRIEF.md
# Two-Bank Level Interrupt Controller

This block gathers forty level-sensitive interrupt lines and presents them to a processor as two active-high requests, a fast request and a normal request. The lines are spread over two banks of up to thirty-two bits. Each bank has its own enable register and its own routing register. A routing bit selects which of the two requests a line feeds. The pending state of every line is captured into a register on each clock, so it follows the input level with one cycle of delay.

A third output is a wake request for a halted core. It considers the enable bits together with an idle mask. When the idle mask is set, every pending line can wake the core, whether or not that line is enabled.

Software reaches the registers through a simple synchronous bus with a byte address, a write strobe, write data and registered read data. The same bus reaches forty priority registers. These registers are stored for a separate priority resolver. The highest-priority slot of the map reads as zero here.

Top module: `dual_bank_intc`

## Requirements
- R1: Source s lands in bank 0 for s in 0..31 and in bank 1 for s in 32..39, at bit position s mod 32. Raw pending reads back at 0x10 for bank 0 and at 0xAC for bank 1.
- R2: The pending bit of a source equals the input level sampled at the previous clock edge. It is set while the input is high and clears once the input drops.
- R3: A route bit of 1 sends a source to the fast request and a route bit of 0 sends it to the normal request. The normal readback is pending AND enable AND NOT route, at 0x00 for bank 0 and 0x9C for bank 1. The fast readback is pending AND enable AND route, at 0x0C for bank 0 and 0xA8 for bank 1.
- R4: `fiq_o` is high exactly when some bank has a bit that is pending, enabled and routed to the fast request. `irq_o` is high exactly when some bank has a bit that is pending, enabled and routed to the normal request.
- R5: A write to control offset 0x14 with bit 0 = 1 clears the idle mask. A write with bit 0 = 0 sets the idle mask to all ones. A read of 0x14 returns 1 when the idle mask is clear and 0 otherwise. After reset the idle mask is clear.
- R6: `wake_o` is high exactly when pending AND (enable OR idle mask) is nonzero in either bank.
- R7: Priority entries 0..31 sit at 0x1C + 4*i and entries 32..39 sit at 0xB0 + 4*(i-32). A write keeps only bit 31 and bits 5:0 and clears every other bit.
- R8: After reset the enable, route and pending bits and all priority entries are zero, and `fiq_o`, `irq_o`, `wake_o` are low.
- R9: A read of an unmapped or misaligned offset, or of the highest-priority slot 0x18, returns zero. A write to any such offset, or to a read-only offset (the pending readbacks), changes no state.
- R10: The enable registers sit at 0x04 and 0xA0 and the route registers at 0x08 and 0xA4. A write updates the register; the bank-1 registers keep bits 7:0 and read zero above. Read data for the address presented in one cycle appears on `rdata_o` after the next clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | NUM_SRC | Interrupt source levels |
| addr_i | input | 8 | Register byte address |
| we_i | input | 1 | Write strobe |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Registered read data |
| fiq_o | output | 1 | Fast interrupt request |
| irq_o | output | 1 | Normal interrupt request |
| wake_o | output | 1 | Wake request for a halted core |

## Verification
A single asserted line is walked across all forty positions to separate the bank boundary and the bit position, then dropped to show that pending clears with the level. Pseudo-random combinations of source, enable, route and idle settings follow, with all-ones and all-zeros corners added. These tell the normal and fast paths apart and show when the idle mask alone raises the wake request. After every step the whole 256-byte address space is read and compared with a model in the bench. A sweep of writes to every read-only, unmapped and misaligned offset is read back in the same way to show that none of them leaves a trace.

// File: rtl/intc_pkg.sv
package intc_pkg;

    localparam int BANK_W = 32;
    localparam int DATA_W = 32;
    localparam int ADDR_W = 8;
    localparam int PRIO_W = 7;   // valid flag + 6-bit identifier

    // fixed offsets (software-visible map)
    localparam int OFS_IRQ0  = 'h00;
    localparam int OFS_MASK0 = 'h04;
    localparam int OFS_RTE0  = 'h08;
    localparam int OFS_FIQ0  = 'h0C;
    localparam int OFS_RAW0  = 'h10;
    localparam int OFS_CTRL  = 'h14;
    localparam int OFS_HIGH  = 'h18;
    localparam int OFS_PLO   = 'h1C;
    localparam int OFS_IRQ1  = 'h9C;
    localparam int OFS_MASK1 = 'hA0;
    localparam int OFS_RTE1  = 'hA4;
    localparam int OFS_FIQ1  = 'hA8;
    localparam int OFS_RAW1  = 'hAC;
    localparam int OFS_PHI   = 'hB0;

    typedef enum logic [3:0] {
        K_NONE, K_IRQ, K_MASK, K_ROUTE, K_FIQ, K_RAW, K_CTRL, K_HIGH, K_PRIO
    } reg_kind_e;

    typedef struct packed {
        reg_kind_e  kind;
        logic       bank;
        logic [5:0] pidx;
    } dec_t;

    function automatic dec_t decode(input logic [ADDR_W-1:0] a, input int nsrc);
        dec_t d;
        int   ai;
        ai     = int'(a);
        d.kind = K_NONE;
        d.bank = 1'b0;
        d.pidx = '0;
        if (a[1:0] == 2'b00) begin
            case (ai)
                OFS_IRQ0:  d.kind = K_IRQ;
                OFS_MASK0: d.kind = K_MASK;
                OFS_RTE0:  d.kind = K_ROUTE;
                OFS_FIQ0:  d.kind = K_FIQ;
                OFS_RAW0:  d.kind = K_RAW;
                OFS_CTRL:  d.kind = K_CTRL;
                OFS_HIGH:  d.kind = K_HIGH;
                OFS_IRQ1:  begin d.kind = K_IRQ;   d.bank = 1'b1; end
                OFS_MASK1: begin d.kind = K_MASK;  d.bank = 1'b1; end
                OFS_RTE1:  begin d.kind = K_ROUTE; d.bank = 1'b1; end
                OFS_FIQ1:  begin d.kind = K_FIQ;   d.bank = 1'b1; end
                OFS_RAW1:  begin d.kind = K_RAW;   d.bank = 1'b1; end
                default: begin
                    if (ai >= OFS_PLO && ai < OFS_PLO + 4 * BANK_W) begin
                        d.kind = K_PRIO;
                        d.pidx = 6'((ai - OFS_PLO) >> 2);
                    end else if (ai >= OFS_PHI && ai < OFS_PHI + 4 * (nsrc - BANK_W)) begin
                        d.kind = K_PRIO;
                        d.pidx = 6'(BANK_W + ((ai - OFS_PHI) >> 2));
                    end
                end
            endcase
        end
        return d;
    endfunction

endpackage

// File: rtl/intc_bank.sv
module intc_bank #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] src_i,
    input  logic         mask_we_i,
    input  logic         route_we_i,
    input  logic [W-1:0] wdata_i,
    input  logic         idle_all_i,
    output logic [W-1:0] mask_o,
    output logic [W-1:0] route_o,
    output logic [W-1:0] pend_o,
    output logic [W-1:0] irq_vec_o,
    output logic [W-1:0] fiq_vec_o,
    output logic         wake_o
);

    typedef struct packed {
        logic [W-1:0] mask;
        logic [W-1:0] route;
        logic [W-1:0] pend;
    } bank_st_t;

    bank_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.pend = src_i;
        if (mask_we_i)  st_d.mask  = wdata_i;
        if (route_we_i) st_d.route = wdata_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign mask_o    = st_q.mask;
    assign route_o   = st_q.route;
    assign pend_o    = st_q.pend;
    assign irq_vec_o = st_q.pend & st_q.mask & ~st_q.route;
    assign fiq_vec_o = st_q.pend & st_q.mask &  st_q.route;
    assign wake_o    = |(st_q.pend & (st_q.mask | {W{idle_all_i}}));

    // R2: captured pending equals the level seen one edge earlier
    p_pend_track_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> st_q.pend == $past(src_i));

    // R10: enable and route hold without their write strobe
    p_mask_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !mask_we_i |=> $stable(st_q.mask));
    p_route_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !route_we_i |=> $stable(st_q.route));

endmodule

// File: rtl/intc_prio_file.sv
module intc_prio_file #(
    parameter int N = 40
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        we_i,
    input  logic [5:0]  widx_i,
    input  logic [31:0] wdata_i,
    input  logic [5:0]  ridx_i,
    output logic [31:0] rdata_o
);
    import intc_pkg::*;

    typedef struct packed {
        logic [N-1:0][PRIO_W-1:0] ent;
    } prio_st_t;

    prio_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (we_i && int'(widx_i) < N)
            st_d.ent[widx_i] = {wdata_i[31], wdata_i[5:0]};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        rdata_o = '0;
        if (int'(ridx_i) < N)
            rdata_o = {st_q.ent[ridx_i][PRIO_W-1], 25'd0, st_q.ent[ridx_i][5:0]};
    end

    // R7: a write stores only the flag and identifier bits
    p_prio_store_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (we_i && int'(widx_i) < N) |=>
            st_q.ent[$past(widx_i)] == {$past(wdata_i[31]), $past(wdata_i[5:0])});

endmodule

// File: rtl/dual_bank_intc.sv
module dual_bank_intc #(
    parameter int NUM_SRC = 40
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_i,
    input  logic [7:0]         addr_i,
    input  logic               we_i,
    input  logic [31:0]        wdata_i,
    output logic [31:0]        rdata_o,
    output logic               fiq_o,
    output logic               irq_o,
    output logic               wake_o
);
    import intc_pkg::*;

    localparam int NBANK = (NUM_SRC + BANK_W - 1) / BANK_W;

    typedef struct packed {
        logic        idle_all;
        logic [31:0] rdata;
    } top_st_t;

    top_st_t st_d, st_q;
    dec_t    dec;

    logic [NBANK-1:0][31:0] mask_w, route_w, pend_w, irqv_w, fiqv_w;
    logic [NBANK-1:0]       wake_b;
    logic [31:0]            prio_rd;

    assign dec = decode(addr_i, NUM_SRC);

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        localparam int LO = b * BANK_W;
        localparam int BW = (NUM_SRC - LO < BANK_W) ? NUM_SRC - LO : BANK_W;

        logic [BW-1:0] m, r, p, iv, fv;

        intc_bank #(.W(BW)) u_bank (
            .clk        (clk),
            .rst_n      (rst_n),
            .src_i      (src_i[LO +: BW]),
            .mask_we_i  (we_i && dec.kind == K_MASK  && dec.bank == 1'(b)),
            .route_we_i (we_i && dec.kind == K_ROUTE && dec.bank == 1'(b)),
            .wdata_i    (wdata_i[BW-1:0]),
            .idle_all_i (st_q.idle_all),
            .mask_o     (m),
            .route_o    (r),
            .pend_o     (p),
            .irq_vec_o  (iv),
            .fiq_vec_o  (fv),
            .wake_o     (wake_b[b])
        );

        assign mask_w[b]  = 32'(m);
        assign route_w[b] = 32'(r);
        assign pend_w[b]  = 32'(p);
        assign irqv_w[b]  = 32'(iv);
        assign fiqv_w[b]  = 32'(fv);
    end

    intc_prio_file #(.N(NUM_SRC)) u_prio (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (we_i && dec.kind == K_PRIO),
        .widx_i  (dec.pidx),
        .wdata_i (wdata_i),
        .ridx_i  (dec.pidx),
        .rdata_o (prio_rd)
    );

    always_comb begin
        st_d = st_q;
        if (we_i && dec.kind == K_CTRL)
            st_d.idle_all = ~wdata_i[0];
        unique case (dec.kind)
            K_IRQ:   st_d.rdata = irqv_w[dec.bank];
            K_FIQ:   st_d.rdata = fiqv_w[dec.bank];
            K_RAW:   st_d.rdata = pend_w[dec.bank];
            K_MASK:  st_d.rdata = mask_w[dec.bank];
            K_ROUTE: st_d.rdata = route_w[dec.bank];
            K_CTRL:  st_d.rdata = {31'd0, ~st_q.idle_all};
            K_PRIO:  st_d.rdata = prio_rd;
            default: st_d.rdata = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rdata_o = st_q.rdata;
    assign irq_o   = |irqv_w;
    assign fiq_o   = |fiqv_w;
    assign wake_o  = |wake_b;

    // R6: any raised request implies the wake request
    p_wake_covers_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o || fiq_o) |-> wake_o);

    // R9: unmapped, misaligned and highest-priority reads give zero
    p_unmapped_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (dec.kind == K_NONE || dec.kind == K_HIGH) |=> rdata_o == 32'd0);

    // R5: control write sets the idle mask from bit 0; otherwise it holds
    p_ctrl_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (we_i && dec.kind == K_CTRL) |=> st_q.idle_all == !$past(wdata_i[0]));
    p_ctrl_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(we_i && dec.kind == K_CTRL) |=> $stable(st_q.idle_all));

endmodule

// File: tb/dual_bank_intc_tb.sv
module dual_bank_intc_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [39:0] src = '0;
    logic [7:0]  addr = '0;
    logic        we = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        fiq, irq, wake;

    int tests = 0;
    int fails = 0;

    // bench model
    logic [31:0] m_mask [2];
    logic [31:0] m_rte  [2];
    logic        m_idle;
    logic [31:0] m_prio [40];
    logic [31:0] lfsr = 32'h1234_5678;

    always #2.5 clk = ~clk;

    dual_bank_intc #(.NUM_SRC(40)) u_dut (
        .clk(clk), .rst_n(rst_n), .src_i(src), .addr_i(addr), .we_i(we),
        .wdata_i(wdata), .rdata_o(rdata), .fiq_o(fiq), .irq_o(irq), .wake_o(wake)
    );

    function automatic logic [31:0] pend_of(input int b);
        return (b == 0) ? src[31:0] : 32'(src[39:32]);
    endfunction

    function automatic logic [31:0] exp_read(input int a);
        int bk;
        if (a % 4 != 0) return 0;
        bk = (a >= 'h9C) ? 1 : 0;
        case (a)
            'h00, 'h9C: return pend_of(bk) & m_mask[bk] & ~m_rte[bk];
            'h0C, 'hA8: return pend_of(bk) & m_mask[bk] &  m_rte[bk];
            'h10, 'hAC: return pend_of(bk);
            'h04, 'hA0: return m_mask[bk];
            'h08, 'hA4: return m_rte[bk];
            'h14:       return {31'd0, ~m_idle};
            default: begin
                if (a >= 'h1C && a <= 'h98) return m_prio[(a - 'h1C) / 4];
                if (a >= 'hB0 && a <= 'hCC) return m_prio[32 + (a - 'hB0) / 4];
                return 0;
            end
        endcase
    endfunction

    function automatic string tag_of(input int a);
        if (a % 4 != 0) return "R9";
        case (a)
            'h00, 'h9C, 'h0C, 'hA8: return "R3";
            'h10, 'hAC:             return "R1";
            'h04, 'hA0, 'h08, 'hA4: return "R10";
            'h14:                   return "R5";
            default: begin
                if ((a >= 'h1C && a <= 'h98) || (a >= 'hB0 && a <= 'hCC)) return "R7";
                return "R9";
            end
        endcase
    endfunction

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp, input string what);
        tests++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s %s got %h exp %h", tag, what, got, exp);
        end
    endtask

    task automatic model_write(input int a, input logic [31:0] v);
        if (a % 4 != 0) return;
        case (a)
            'h04: m_mask[0] = v;
            'hA0: m_mask[1] = v & 32'hFF;
            'h08: m_rte[0]  = v;
            'hA4: m_rte[1]  = v & 32'hFF;
            'h14: m_idle    = ~v[0];
            default: begin
                if (a >= 'h1C && a <= 'h98) m_prio[(a - 'h1C) / 4] = v & 32'h8000_003F;
                if (a >= 'hB0 && a <= 'hCC) m_prio[32 + (a - 'hB0) / 4] = v & 32'h8000_003F;
            end
        endcase
    endtask

    // all tasks start and end just after a falling edge
    task automatic do_write(input int a, input logic [31:0] v);
        addr = 8'(a); we = 1'b1; wdata = v;
        @(negedge clk);
        we = 1'b0;
        model_write(a, v);
    endtask

    task automatic do_read(input int a, output logic [31:0] d);
        addr = 8'(a); we = 1'b0;
        @(negedge clk);
        d = rdata;
    endtask

    task automatic set_src(input logic [39:0] v);
        src = v;
        @(negedge clk);
    endtask

    task automatic sweep();
        logic [31:0] d;
        for (int a = 0; a < 256; a++) begin
            do_read(a, d);
            chk(tag_of(a), d, exp_read(a), $sformatf("addr %h", a));
        end
    endtask

    task automatic chk_outs(input string ctx);
        logic [31:0] fv, iv, wv;
        fv = 0; iv = 0; wv = 0;
        for (int b = 0; b < 2; b++) begin
            fv |= pend_of(b) & m_mask[b] & m_rte[b];
            iv |= pend_of(b) & m_mask[b] & ~m_rte[b];
            wv |= pend_of(b) & (m_mask[b] | {32{m_idle}});
        end
        chk("R4", 32'(fiq), 32'(|fv), {ctx, " fiq"});
        chk("R4", 32'(irq), 32'(|iv), {ctx, " irq"});
        chk("R6", 32'(wake), 32'(|wv), {ctx, " wake"});
    endtask

    function automatic logic [31:0] next_rand();
        lfsr ^= lfsr << 13;
        lfsr ^= lfsr >> 17;
        lfsr ^= lfsr << 5;
        return lfsr;
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        tests++; fails++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [31:0] d;
        m_mask = '{0, 0}; m_rte = '{0, 0}; m_idle = 1'b0;
        for (int i = 0; i < 40; i++) m_prio[i] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R8: reset state
        chk("R8", {29'd0, fiq, irq, wake}, 32'd0, "outputs after reset");
        sweep();

        // R1 / R2: walking single source
        for (int s = 0; s < 40; s++) begin
            set_src(40'd1 << s);
            do_read((s < 32) ? 'h10 : 'hAC, d);
            chk("R1", d, 32'd1 << (s % 32), $sformatf("source %0d", s));
            do_read((s < 32) ? 'hAC : 'h10, d);
            chk("R1", d, 32'd0, $sformatf("other bank, source %0d", s));
            set_src('0);
            do_read((s < 32) ? 'h10 : 'hAC, d);
            chk("R2", d, 32'd0, $sformatf("drop of source %0d", s));
        end

        // R3 / R4 / R6 / R10 / R5: patterned and pseudo-random settings
        for (int k = 0; k < 14; k++) begin
            logic [31:0] m0, m1, r0, r1, c;
            logic [39:0] sv;
            m0 = next_rand(); m1 = next_rand(); r0 = next_rand(); r1 = next_rand();
            c  = next_rand();
            sv = {next_rand(), next_rand()};
            if (k == 0) begin m0 = '1; m1 = '1; r0 = '0; r1 = '0; sv = '1; c = 1; end
            if (k == 1) begin m0 = '1; m1 = '1; r0 = '1; r1 = '1; sv = '1; c = 1; end
            if (k == 2) begin m0 = '0; m1 = '0; sv = 40'h80_0000_0001; c = 0; end
            if (k == 3) begin m0 = '0; m1 = '0; sv = 40'h01_0000_0000; c = 1; end
            if (k == 4) begin m0 = '0; m1 = 32'h80; r1 = 32'h80; sv = 40'h80_0000_0000; c = 1; end
            do_write('h04, m0); do_write('hA0, m1);
            do_write('h08, r0); do_write('hA4, r1);
            do_write('h14, c);
            set_src(sv);
            chk_outs($sformatf("pattern %0d", k));
            sweep();
        end

        // R7: priority entries
        for (int i = 0; i < 40; i++)
            do_write((i < 32) ? 'h1C + 4 * i : 'hB0 + 4 * (i - 32),
                     32'hFFFF_FFFF ^ (32'(i) * 32'h0101_0101));
        sweep();

        // R9: writes to read-only, unmapped and misaligned offsets
        for (int a = 0; a < 256; a++) begin
            if (!(a % 4 == 0 && (a == 'h04 || a == 'hA0 || a == 'h08 || a == 'hA4 ||
                  a == 'h14 || (a >= 'h1C && a <= 'h98) || (a >= 'hB0 && a <= 'hCC))))
                do_write(a, 32'hFFFF_FFFF);
        end
        chk_outs("after ignored writes R9");
        sweep();

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule